// File: doc/BRIEF.md
# UART Receive FIFO with Watermark

This block is the receive-side buffer of a serial port. A deserializer hands it one received word at a time, and it queues the words in a small first-in first-out store until a processor reads them through three word registers: a data register, a level register and a control/status register. Reading the data register returns the oldest queued word and removes it from the queue in the same cycle.

Software uses a programmable watermark to choose how many words should collect before it is told that data is waiting. The data-ready output is raised only while the fill count is strictly above the watermark. Software can also read the live fill count and an empty bit, and drain the queue until the empty bit is set. Reading the data register while the queue is empty sets a sticky underflow flag. A word that arrives when the queue is full is discarded and sets a sticky overflow flag. Both flags are cleared by writing 1 to their bit, and each has its own enable that routes it to the interrupt output. A self-clearing flush bit empties the queue. When queueing is disabled, the block acts as a single-word holding register.

Top module: `rx_water_fifo`

## Requirements
- R1: With queueing enabled (CTRL bit 0 = 1), `data_ready` is 1 exactly when the fill count is strictly greater than the watermark, which is held in LEVEL bits [2:0].
- R2: With queueing enabled, a watermark equal to or above the depth (4) keeps `data_ready` at 0 at every fill level.
- R3: CTRL bits [10:8] are a read-only size code, equal to log2(depth)-1 for a depth above 1, so that depth = 2^(code+1). With the default depth of 4 the code reads 1.
- R4: LEVEL bits [18:16] read back the current fill count (read-only), and CTRL bit 4 reads 1 whenever the queue is empty.
- R5: A read of the data register (address 0) returns the oldest word in bits [7:0] and removes it. A read while the queue is empty returns 0 and sets the underflow flag, CTRL bit 5.
- R6: Writing 1 to CTRL bit 5 clears the underflow flag. Writing 0 there leaves it unchanged, and the flag stays set until it is cleared.
- R7: Writing 1 to CTRL bit 3 discards every queued word, so the count becomes 0 and the empty bit becomes 1. Bit 3 always reads 0.
- R8: `irq` = (underflow AND CTRL bit 1) OR (overflow AND CTRL bit 2).
- R9: A word that arrives while the queue holds its capacity, with no pop in the same cycle, is dropped. This sets the sticky overflow flag, CTRL bit 6, which is cleared by writing 1 to that bit.
- R10: With CTRL bit 0 = 0 (the reset value), the capacity is one word and `data_ready` is 1 whenever a word is held, whatever the watermark.
- R11: A push and a pop in the same cycle leave the count unchanged. At full capacity the incoming word is accepted and no overflow is flagged.
- R12: After reset the count is 0, all flags and enables are 0, the watermark is 0, and `data_ready` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Deserializer presents a received word |
| in_data | input | DATA_W | Received word |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 data, 1 level, 2 control/status |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the selected register (combinational) |
| data_ready | output | 1 | Received data waiting above the watermark |
| irq | output | 1 | Gated underflow/overflow interrupt |

## Verification
The bench sets the fill count equal to the watermark and then one above it. A design that compares with greater-or-equal would raise `data_ready` one word early. It also sets a watermark of 4 with a full queue, where a wrong compare would assert `data_ready`. It pushes into a full queue while a read pops from it in the same cycle: a design that tests fullness before the pop would drop the word and flag overflow, and the later drain would show a missing word. It also writes 0 and then 1 to the sticky flags, reads an empty queue, and uses the one-word mode, where a design that ignored the enable would buffer a second word or wait for the watermark.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int unsigned BUS_W = 32;

    typedef enum logic [1:0] {
        RA_DATA  = 2'd0,
        RA_LEVEL = 2'd1,
        RA_CTRL  = 2'd2
    } rxq_addr_e;

    // control/status bit positions
    localparam int unsigned CB_EN    = 0;
    localparam int unsigned CB_UFIE  = 1;
    localparam int unsigned CB_OFIE  = 2;
    localparam int unsigned CB_FLUSH = 3;
    localparam int unsigned CB_EMPTY = 4;
    localparam int unsigned CB_UF    = 5;
    localparam int unsigned CB_OF    = 6;
    localparam int unsigned CB_SIZE  = 8;
    // level register: count field position
    localparam int unsigned LB_CNT   = 16;

    typedef struct packed {
        logic fifo_en;
        logic uf_ie;
        logic of_ie;
    } rxq_cfg_t;

    typedef struct packed {
        logic push;
        logic pop;
        logic flush;
        logic drop;
        logic empty_rd;
    } rxq_evt_t;

    function automatic logic [2:0] size_code(input int unsigned depth);
        if (depth <= 1) return 3'd0;
        return 3'($clog2(depth) - 1);
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 4,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic              pop,
    input  logic              flush,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] head,
    output logic [CNT_W-1:0]  count
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        if (32'(p) == DEPTH - 1) return '0;
        return p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= step(wr_ptr);
            if (pop)  rd_ptr <= step(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head = mem[rd_ptr];

endmodule

// File: rtl/rxq_ready.sv
module rxq_ready #(
    parameter int unsigned CNT_W = 3
) (
    input  logic             fifo_en,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] mark,
    output logic             ready
);

    always_comb begin
        if (fifo_en) ready = (count > mark);
        else         ready = (count != '0);
    end

endmodule

// File: rtl/rxq_regs.sv
module rxq_regs
    import rxq_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 4,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic              in_valid,
    input  logic [CNT_W-1:0]  count,
    input  logic [DATA_W-1:0] head,
    output logic [BUS_W-1:0]  rdata,
    output rxq_evt_t          evt,
    output rxq_cfg_t          cfg,
    output logic [CNT_W-1:0]  mark,
    output logic              uf_flag,
    output logic              of_flag,
    output logic              irq
);

    localparam logic [CNT_W-1:0] CAP_FULL = CNT_W'(DEPTH);
    localparam logic [2:0]       SIZE_F   = size_code(DEPTH);

    logic [CNT_W-1:0] cap;
    logic             full;
    logic             data_rd;
    logic             ctrl_wr;
    logic             level_wr;
    logic             unused_wbits;

    assign unused_wbits = ^{wdata[BUS_W-1:7], wdata[4]};

    always_comb begin
        cap       = cfg.fifo_en ? CAP_FULL : CNT_W'(1);
        full      = (count >= cap);
        data_rd   = rd_en && (addr == RA_DATA);
        ctrl_wr   = wr_en && (addr == RA_CTRL);
        level_wr  = wr_en && (addr == RA_LEVEL);
        evt.flush    = ctrl_wr && wdata[CB_FLUSH];
        evt.pop      = data_rd && (count != '0);
        evt.empty_rd = data_rd && (count == '0);
        evt.push     = in_valid && !evt.flush && (!full || evt.pop);
        evt.drop     = in_valid && !evt.flush && full && !evt.pop;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg     <= '0;
            mark    <= '0;
            uf_flag <= 1'b0;
            of_flag <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                cfg.fifo_en <= wdata[CB_EN];
                cfg.uf_ie   <= wdata[CB_UFIE];
                cfg.of_ie   <= wdata[CB_OFIE];
            end
            if (level_wr) mark <= wdata[CNT_W-1:0];

            if (evt.empty_rd)               uf_flag <= 1'b1;
            else if (ctrl_wr && wdata[CB_UF]) uf_flag <= 1'b0;

            if (evt.drop)                   of_flag <= 1'b1;
            else if (ctrl_wr && wdata[CB_OF]) of_flag <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            RA_DATA: begin
                if (count != '0) rdata[DATA_W-1:0] = head;
            end
            RA_LEVEL: begin
                rdata[CNT_W-1:0]         = mark;
                rdata[LB_CNT +: CNT_W]   = count;
            end
            RA_CTRL: begin
                rdata[CB_EN]         = cfg.fifo_en;
                rdata[CB_UFIE]       = cfg.uf_ie;
                rdata[CB_OFIE]       = cfg.of_ie;
                rdata[CB_EMPTY]      = (count == '0);
                rdata[CB_UF]         = uf_flag;
                rdata[CB_OF]         = of_flag;
                rdata[CB_SIZE +: 3]  = SIZE_F;
            end
            default: rdata = '0;
        endcase
    end

    assign irq = (uf_flag && cfg.uf_ie) || (of_flag && cfg.of_ie);

endmodule

// File: rtl/rx_water_fifo.sv
module rx_water_fifo
    import rxq_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 4,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              data_ready,
    output logic              irq
);

    rxq_evt_t          evt;
    rxq_cfg_t          cfg;
    logic [CNT_W-1:0]  fill_cnt;
    logic [CNT_W-1:0]  mark_q;
    logic [DATA_W-1:0] head;
    logic              uf_flag;
    logic              of_flag;
    logic              fifo_on;

    assign fifo_on = cfg.fifo_en;

    rxq_regs #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .in_valid (in_valid),
        .count    (fill_cnt),
        .head     (head),
        .rdata    (rdata),
        .evt      (evt),
        .cfg      (cfg),
        .mark     (mark_q),
        .uf_flag  (uf_flag),
        .of_flag  (of_flag),
        .irq      (irq)
    );

    rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst   (rst),
        .push  (evt.push),
        .pop   (evt.pop),
        .flush (evt.flush),
        .wdata (in_data),
        .head  (head),
        .count (fill_cnt)
    );

    rxq_ready #(.CNT_W(CNT_W)) u_ready (
        .fifo_en (fifo_on),
        .count   (fill_cnt),
        .mark    (mark_q),
        .ready   (data_ready)
    );

endmodule

// File: rtl/rx_water_fifo_chk.sv
module rx_water_fifo_chk #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned CNT_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             rd_en,
    input logic             wr_en,
    input logic [1:0]       addr,
    input logic [31:0]      wdata,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] mark,
    input logic             fifo_en,
    input logic             uf_flag,
    input logic             of_flag,
    input logic             data_ready
);

    logic data_rd;
    logic flush_wr;
    logic uf_clr_wr;

    assign data_rd   = rd_en && (addr == 2'd0);
    assign flush_wr  = wr_en && (addr == 2'd2) && wdata[3];
    assign uf_clr_wr = wr_en && (addr == 2'd2) && wdata[5];

    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH)); // R9

    AST_HIGH_MARK: assert property (@(posedge clk) disable iff (rst)
        (fifo_en && mark >= CNT_W'(DEPTH)) |-> !data_ready); // R2

    AST_HOLD_READY: assert property (@(posedge clk) disable iff (rst)
        (!fifo_en && count != '0) |-> data_ready); // R10

    AST_UF_SET: assert property (@(posedge clk) disable iff (rst)
        (data_rd && count == '0) |=> uf_flag); // R5

    AST_UF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (uf_flag && !uf_clr_wr) |=> uf_flag); // R6

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        flush_wr |=> (count == '0)); // R7

    AST_OF_DROP: assert property (@(posedge clk) disable iff (rst)
        (fifo_en && in_valid && count == CNT_W'(DEPTH) && !data_rd && !flush_wr)
        |=> (of_flag && count == CNT_W'(DEPTH))); // R9

    AST_PUSH_POP: assert property (@(posedge clk) disable iff (rst)
        (in_valid && data_rd && count != '0 && !flush_wr)
        |=> (count == $past(count))); // R11

endmodule

bind rx_water_fifo rx_water_fifo_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .rd_en      (rd_en),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .count      (fill_cnt),
    .mark       (mark_q),
    .fifo_en    (fifo_on),
    .uf_flag    (uf_flag),
    .of_flag    (of_flag),
    .data_ready (data_ready)
);

// File: tb/rx_water_fifo_bench.sv
`timescale 1ns/1ps
module rx_water_fifo_bench;

    localparam logic [1:0] OP_PUSH = 2'd0;
    localparam logic [1:0] OP_POP  = 2'd1;
    localparam logic [1:0] OP_MARK = 2'd2;
    localparam int NV = 23;

    typedef struct packed {
        logic [1:0] op;
        logic [7:0] arg;
        logic [2:0] cnt;
        logic       rdy;
    } vec_t;

    // R1 R2: count after the step and expected data_ready
    localparam vec_t VECS [NV] = '{
        '{OP_PUSH, 8'hA1, 3'd1, 1'b0},
        '{OP_PUSH, 8'hB2, 3'd2, 1'b1},
        '{OP_POP,  8'hA1, 3'd1, 1'b0},
        '{OP_PUSH, 8'hC3, 3'd2, 1'b1},
        '{OP_PUSH, 8'hD4, 3'd3, 1'b1},
        '{OP_PUSH, 8'hE5, 3'd4, 1'b1},
        '{OP_PUSH, 8'hF6, 3'd4, 1'b1},
        '{OP_MARK, 8'h03, 3'd4, 1'b1},
        '{OP_POP,  8'hB2, 3'd3, 1'b0},
        '{OP_MARK, 8'h00, 3'd3, 1'b1},
        '{OP_POP,  8'hC3, 3'd2, 1'b1},
        '{OP_POP,  8'hD4, 3'd1, 1'b1},
        '{OP_POP,  8'hE5, 3'd0, 1'b0},
        '{OP_MARK, 8'h04, 3'd0, 1'b0},
        '{OP_PUSH, 8'h11, 3'd1, 1'b0},
        '{OP_PUSH, 8'h22, 3'd2, 1'b0},
        '{OP_PUSH, 8'h33, 3'd3, 1'b0},
        '{OP_PUSH, 8'h44, 3'd4, 1'b0},
        '{OP_POP,  8'h11, 3'd3, 1'b0},
        '{OP_MARK, 8'h02, 3'd3, 1'b1},
        '{OP_POP,  8'h22, 3'd2, 1'b0},
        '{OP_POP,  8'h33, 3'd1, 1'b0},
        '{OP_POP,  8'h44, 3'd0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        data_ready;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] rv;

    always #2.5 clk = ~clk;

    rx_water_fifo u_rx_water_fifo (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .data_ready(data_ready), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0; wdata = '0;
        @(negedge clk);
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(posedge clk); #1;
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic push(input logic [7:0] d);
        in_valid = 1'b1; in_data = d;
        @(posedge clk); #1;
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic push_pop(input logic [7:0] d, output logic [31:0] q);
        in_valid = 1'b1; in_data = d; rd_en = 1'b1; addr = 2'd0;
        #1 q = rdata;
        @(posedge clk); #1;
        in_valid = 1'b0; rd_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic level_count(output logic [31:0] c);
        logic [31:0] t;
        bus_rd(2'd1, t);
        c = 32'(t[18:16]);
    endtask

    initial begin
        #(5.0 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12 reset state, R3 size code, R4 empty bit
        check("R12 data_ready", 32'(data_ready), 32'd0);
        check("R12 irq", 32'(irq), 32'd0);
        bus_rd(2'd2, rv); check("R12 R3 R4 ctrl", rv, 32'h0000_0110);
        bus_rd(2'd1, rv); check("R12 R4 level", rv, 32'h0);

        bus_wr(2'd2, 32'h1);
        bus_wr(2'd1, 32'h1);

        for (int i = 0; i < NV; i++) begin
            case (VECS[i].op)
                OP_PUSH: push(VECS[i].arg);
                OP_POP: begin
                    bus_rd(2'd0, rv);
                    check("R5 pop data", rv, 32'(VECS[i].arg));
                end
                default: bus_wr(2'd1, 32'(VECS[i].arg));
            endcase
            level_count(rv);
            check("R4 count", rv, 32'(VECS[i].cnt));
            check("R1 R2 data_ready", 32'(data_ready), 32'(VECS[i].rdy));
        end

        // R9 overflow flag from the dropped word, R8 gating
        bus_rd(2'd2, rv); check("R9 overflow flag", 32'(rv[6]), 32'd1);
        check("R8 irq gated off", 32'(irq), 32'd0);
        bus_wr(2'd2, 32'h5);
        check("R8 irq overflow", 32'(irq), 32'd1);
        bus_wr(2'd2, 32'h41);
        bus_rd(2'd2, rv); check("R9 overflow cleared", 32'(rv[6]), 32'd0);
        check("R8 irq after clear", 32'(irq), 32'd0);

        // R5 R6 underflow
        bus_rd(2'd0, rv); check("R5 empty read data", rv, 32'h0);
        bus_rd(2'd2, rv); check("R5 underflow set", 32'(rv[5]), 32'd1);
        bus_wr(2'd2, 32'h1);
        bus_rd(2'd2, rv); check("R6 write 0 keeps flag", 32'(rv[5]), 32'd1);
        bus_wr(2'd2, 32'h3);
        check("R8 irq underflow", 32'(irq), 32'd1);
        bus_wr(2'd2, 32'h23);
        bus_rd(2'd2, rv); check("R6 write 1 clears", 32'(rv[5]), 32'd0);
        check("R8 irq cleared", 32'(irq), 32'd0);

        // R7 flush
        bus_wr(2'd2, 32'h1);
        push(8'h71); push(8'h72);
        level_count(rv); check("R4 count before flush", rv, 32'd2);
        bus_wr(2'd2, 32'h9);
        level_count(rv); check("R7 count after flush", rv, 32'd0);
        bus_rd(2'd2, rv); check("R7 ctrl after flush", rv, 32'h0000_0111);

        // R11 push and pop together at full
        bus_wr(2'd1, 32'h2);
        push(8'h51); push(8'h52); push(8'h53); push(8'h54);
        push_pop(8'h55, rv); check("R11 pop data at full", rv, 32'h51);
        level_count(rv); check("R11 count unchanged", rv, 32'd4);
        bus_rd(2'd2, rv); check("R11 no overflow", 32'(rv[6]), 32'd0);
        for (int k = 0; k < 4; k++) begin
            bus_rd(2'd0, rv); check("R11 drain order", rv, 32'(8'h52 + k));
        end

        // R10 holding-register mode
        bus_wr(2'd2, 32'h0);
        bus_wr(2'd1, 32'h3);
        push(8'h66);
        check("R10 ready with one word", 32'(data_ready), 32'd1);
        push(8'h77);
        level_count(rv); check("R10 capacity one", rv, 32'd1);
        bus_rd(2'd2, rv); check("R10 R9 overflow in hold mode", 32'(rv[6]), 32'd1);
        bus_rd(2'd0, rv); check("R10 held word", rv, 32'h66);
        check("R10 ready after read", 32'(data_ready), 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule